// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact 32-bit processor that completes one instruction on every clock edge. Each instruction is 32 bits wide and uses one of three fixed layouts. It is fetched from an internal word-indexed instruction array and runs against a 32-entry register file and an internal data array. Arithmetic operates only on registers. Data memory is reached only through word loads and stores, which add a sign-extended 16-bit offset to a base register and use byte addressing.

The supported operations are:
- register add, subtract and signed set-less-than;
- immediate add, signed set-less-than, AND, OR and load-upper;
- word load and store;
- equal and not-equal branches;
- absolute jump, jump-and-link and jump-through-register.

A full 32-bit constant is built with load-upper followed by an OR-immediate of the low half.

Memory images go in through two write ports while reset is held. A debug port shows the program counter and reads any register combinationally.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register reads 0.
- R2: One instruction completes per clock. Every non-control instruction leaves PC+4 as the next PC.
- R3: Register 0 always reads 0, and a write addressed to it is discarded.
- R4: Fields are decoded as op=[31:26], rs=[25:21], rt=[20:16], rd=[15:11], funct=[5:0] and imm=[15:0].
  - Op 0 with funct 32 is add and funct 34 is sub, writing rd.
  - Op 8 is addi, using a sign-extended immediate and writing rt.
  - All three wrap modulo 2^32 without a trap.
- R5: Op 0 funct 42 (slt) and op 10 (slti, sign-extended immediate) write 1 if rs is less than the second operand as a signed value, else 0.
- R6: Op 12 (andi) and op 13 (ori) zero-extend the immediate.
- R7: Op 15 (lui) writes imm<<16 with the low half zero. A following ori completes a 32-bit constant.
- R8: Op 35 (lw, writes rt) and op 43 (sw, stores rt) access the word at byte address rs + sign-extended imm. Address bits [1:0] are ignored.
- R9: Op 4 (beq) and op 5 (bne) compare rs with rt. When taken, the next PC is PC+4+(sign-extended imm<<2); otherwise it is PC+4.
- R10: Op 2 (j) sets the PC to {PC+4[31:28], instr[25:0], 00}. Op 3 (jal) does the same and also writes PC+4 into register 31.
- R11: Op 0 funct 8 (jr) loads the PC from register rs and writes no register.
- R12: Any other opcode or funct executes as a no-op: no register or memory change, and the next PC is PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction array write enable |
| imem_waddr | input | IAW (6) | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dmem_we | input | 1 | Data array write enable (wins over a store) |
| dmem_waddr | input | DAW (6) | Data word index to write |
| dmem_wdata | input | 32 | Data word to write |
| dbg_reg_sel | input | 5 | Register number to read on the debug port |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
Jump-and-link writes register 31 and redirects the PC in the same clock. A wrong link value or a wrong target would only show up later, when the jump-through-register returns. The bench provokes this with a call into a short routine that returns through register 31 and then hits an undefined instruction whose rt and rd fields both name register 31. A behavioural instruction-level model steps alongside the core. Every cycle the bench compares the PC and a rotating register against the model. At the end it compares fixed expected values for the link register, the instruction after the return and the register that the no-op must not touch.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RNUM = 32;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_J     = 6'd2;
    localparam logic [5:0] OPC_JAL   = 6'd3;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_BNE   = 6'd5;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_SLTI  = 6'd10;
    localparam logic [5:0] OPC_ANDI  = 6'd12;
    localparam logic [5:0] OPC_ORI   = 6'd13;
    localparam logic [5:0] OPC_LUI   = 6'd15;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_AND,
        ALU_OR,
        ALU_HI
    } alu_op_e;

    typedef enum logic [2:0] {
        NXT_SEQ,
        NXT_BEQ,
        NXT_BNE,
        NXT_JABS,
        NXT_JREG
    } next_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    link;
        logic    src_imm;
        logic    imm_zext;
        alu_op_e alu;
        logic    mem_rd;
        logic    mem_wr;
        next_e   nxt;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl          = '0;
        ctrl.alu      = ALU_ADD;
        ctrl.nxt      = NXT_SEQ;
        case (opcode)
            OPC_RTYPE: begin
                case (funct)
                    FN_ADD: begin
                        ctrl.reg_we = 1'b1;
                        ctrl.dst_rd = 1'b1;
                        ctrl.alu    = ALU_ADD;
                    end
                    FN_SUB: begin
                        ctrl.reg_we = 1'b1;
                        ctrl.dst_rd = 1'b1;
                        ctrl.alu    = ALU_SUB;
                    end
                    FN_SLT: begin
                        ctrl.reg_we = 1'b1;
                        ctrl.dst_rd = 1'b1;
                        ctrl.alu    = ALU_SLT;
                    end
                    FN_JR: ctrl.nxt = NXT_JREG;
                    default: ;
                endcase
            end
            OPC_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu     = ALU_ADD;
            end
            OPC_SLTI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu     = ALU_SLT;
            end
            OPC_ANDI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu      = ALU_AND;
            end
            OPC_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu      = ALU_OR;
            end
            OPC_LUI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu      = ALU_HI;
            end
            OPC_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: ctrl.nxt = NXT_BEQ;
            OPC_BNE: ctrl.nxt = NXT_BNE;
            OPC_J:   ctrl.nxt = NXT_JABS;
            OPC_JAL: begin
                ctrl.nxt    = NXT_JABS;
                ctrl.reg_we = 1'b1;
                ctrl.link   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    localparam int HALF = W / 2;

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_HI:  y = {b[HALF-1:0], {HALF{1'b0}}};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs_q[ra3];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            imem_we,
    input  logic [IAW-1:0]  imem_waddr,
    input  logic [XLEN-1:0] imem_wdata,
    input  logic            dmem_we,
    input  logic [DAW-1:0]  dmem_waddr,
    input  logic [XLEN-1:0] dmem_wdata,
    input  logic [4:0]      dbg_reg_sel,
    output logic [XLEN-1:0] dbg_reg_data,
    output logic [XLEN-1:0] dbg_pc
);

    localparam int HALF = XLEN / 2;
    localparam logic [4:0] LINK_REG = 5'd31;

    core_state_t st_d, st_q;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    logic [4:0]      rs_a, rt_a, rd_a;
    logic [HALF-1:0] imm;
    logic [XLEN-1:0] imm_ext, rs_data, rt_data, alu_b, alu_y, mem_q;
    logic [XLEN-1:0] pc4, br_tgt, j_tgt;
    logic            rf_we;
    logic [4:0]      rf_wa;
    logic [XLEN-1:0] rf_wd;
    logic [DAW-1:0]  d_idx;

    assign instr = imem[st_q.pc[IAW+1:2]];
    assign rs_a  = instr[25:21];
    assign rt_a  = instr[20:16];
    assign rd_a  = instr[15:11];
    assign imm   = instr[HALF-1:0];

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.W(XLEN), .N(RNUM)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (rs_a),
        .ra2 (rt_a),
        .ra3 (dbg_reg_sel),
        .rd1 (rs_data),
        .rd2 (rt_data),
        .rd3 (dbg_reg_data),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd)
    );

    assign imm_ext = ctrl.imm_zext ? {{HALF{1'b0}}, imm} : {{HALF{imm[HALF-1]}}, imm};
    assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

    sc_alu #(.W(XLEN)) u_alu (
        .a  (rs_data),
        .b  (alu_b),
        .op (ctrl.alu),
        .y  (alu_y)
    );

    assign d_idx = alu_y[DAW+1:2];
    assign mem_q = dmem[d_idx];

    assign rf_we = ctrl.reg_we & ~rst;
    assign rf_wa = ctrl.link ? LINK_REG : (ctrl.dst_rd ? rd_a : rt_a);
    assign rf_wd = ctrl.link ? pc4 : (ctrl.mem_rd ? mem_q : alu_y);

    assign pc4    = st_q.pc + XLEN'(4);
    assign br_tgt = pc4 + {imm_ext[XLEN-3:0], 2'b00};
    assign j_tgt  = {pc4[XLEN-1:28], instr[25:0], 2'b00};

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else begin
            case (ctrl.nxt)
                NXT_BEQ:  st_d.pc = (rs_data == rt_data) ? br_tgt : pc4;
                NXT_BNE:  st_d.pc = (rs_data != rt_data) ? br_tgt : pc4;
                NXT_JABS: st_d.pc = j_tgt;
                NXT_JREG: st_d.pc = rs_data;
                default:  st_d.pc = pc4;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (imem_we) begin
            imem[imem_waddr] <= imem_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (dmem_we) begin
            dmem[dmem_waddr] <= dmem_wdata;
        end else if (!rst && ctrl.mem_wr) begin
            dmem[d_idx] <= rt_data;
        end
    end

    assign dbg_pc = st_q.pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] instr,
    input logic            rf_we,
    input logic [4:0]      rf_wa,
    input logic [XLEN-1:0] rf_wd,
    input logic [XLEN-1:0] rs_data
);

    logic [5:0] op;
    logic [5:0] fn;
    logic       is_ctrl;
    logic       is_known;

    assign op = instr[31:26];
    assign fn = instr[5:0];
    assign is_ctrl = (op == OPC_J) || (op == OPC_JAL) || (op == OPC_BEQ) ||
                     (op == OPC_BNE) || ((op == OPC_RTYPE) && (fn == FN_JR));
    assign is_known = ((op == OPC_RTYPE) &&
                       ((fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_SLT) || (fn == FN_JR))) ||
                      (op == OPC_ADDI) || (op == OPC_SLTI) || (op == OPC_ANDI) ||
                      (op == OPC_ORI) || (op == OPC_LUI) || (op == OPC_LW) ||
                      (op == OPC_SW) || is_ctrl;

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0));

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        !is_ctrl |=> (pc == $past(pc) + 32'd4));

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_data == '0));

    // R7
    hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_LUI) |-> (rf_we && (rf_wd[15:0] == 16'h0000) && (rf_wd[31:16] == instr[15:0])));

    // R10
    link_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JAL) |-> (rf_we && (rf_wa == 5'd31) && (rf_wd == pc + 32'd4)));

    // R12
    undef_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        !is_known |-> !rf_we);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (dbg_pc),
    .instr   (instr),
    .rf_we   (rf_we),
    .rf_wa   (rf_wa),
    .rf_wd   (rf_wd),
    .rs_data (rs_data)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;

    localparam int  CLK_NS = 20;
    localparam int  WORDS  = 64;
    localparam int  RUN    = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [5:0]  dmem_waddr = '0;
    logic [31:0] dmem_wdata = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [31:0] dbg_pc;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    logic [31:0] m_reg  [32];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_imem [WORDS];
    logic [31:0] m_pc;

    always #(CLK_NS/2) clk = ~clk;

    sc_core dut (
        .clk          (clk),
        .rst          (rst),
        .imem_we      (imem_we),
        .imem_waddr   (imem_waddr),
        .imem_wdata   (imem_wdata),
        .dmem_we      (dmem_we),
        .dmem_waddr   (dmem_waddr),
        .dmem_wdata   (dmem_wdata),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_pc       (dbg_pc)
    );

    function automatic logic [31:0] enc_r(input int fn, input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input int op, input int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic mwr(input int r, input logic [31:0] v);
        if (r != 0) m_reg[r] = v;
    endtask

    task automatic model_step();
        logic [31:0] ins, a, b, simm, zimm, npc, ea;
        ins  = m_imem[m_pc[7:2]];
        a    = m_reg[ins[25:21]];
        b    = m_reg[ins[20:16]];
        simm = {{16{ins[15]}}, ins[15:0]};
        zimm = {16'd0, ins[15:0]};
        npc  = m_pc + 4;
        ea   = a + simm;
        case (int'(ins[31:26]))
            0: case (int'(ins[5:0]))
                32: mwr(ins[15:11], a + b);
                34: mwr(ins[15:11], a - b);
                42: mwr(ins[15:11], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
                8:  npc = a;
                default: ;
            endcase
            8:  mwr(ins[20:16], a + simm);
            10: mwr(ins[20:16], ($signed(a) < $signed(simm)) ? 32'd1 : 32'd0);
            12: mwr(ins[20:16], a & zimm);
            13: mwr(ins[20:16], a | zimm);
            15: mwr(ins[20:16], {ins[15:0], 16'h0000});
            35: mwr(ins[20:16], m_dmem[ea[7:2]]);
            43: m_dmem[ea[7:2]] = b;
            4:  if (a == b) npc = npc + {simm[29:0], 2'b00};
            5:  if (a != b) npc = npc + {simm[29:0], 2'b00};
            2:  npc = {npc[31:28], ins[25:0], 2'b00};
            3:  begin
                    mwr(31, m_pc + 4);
                    npc = {npc[31:28], ins[25:0], 2'b00};
                end
            default: ;
        endcase
        m_pc = npc;
    endtask

    task automatic reg_at(input int r, output logic [31:0] v);
        @(negedge clk);
        dbg_reg_sel = 5'(r);
        #1;
        v = dbg_reg_data;
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            m_imem[i] = 32'd0;
            m_dmem[i] = 32'd0;
        end
        m_imem[0]  = enc_i(15, 0, 1, 16'h1234);
        m_imem[1]  = enc_i(13, 1, 1, 16'hABCD);
        m_imem[2]  = enc_i(8, 0, 2, 16'hFFFB);
        m_imem[3]  = enc_i(12, 2, 3, 16'hFF0F);
        m_imem[4]  = enc_r(42, 2, 0, 4);
        m_imem[5]  = enc_i(10, 1, 5, 16'hFFFF);
        m_imem[6]  = enc_r(34, 0, 2, 6);
        m_imem[7]  = enc_r(32, 1, 1, 0);
        m_imem[8]  = enc_i(8, 0, 7, 16'd8);
        m_imem[9]  = enc_i(43, 7, 1, 16'd4);
        m_imem[10] = enc_i(35, 0, 8, 16'd12);
        m_imem[11] = enc_i(35, 7, 9, 16'hFFFC);
        m_imem[12] = enc_i(4, 4, 5, 16'd5);
        m_imem[13] = enc_i(5, 4, 5, 16'd1);
        m_imem[14] = enc_i(8, 0, 10, 16'd99);
        m_imem[15] = enc_j(3, 18);
        m_imem[16] = enc_i(8, 0, 11, 16'd7);
        m_imem[17] = enc_j(2, 20);
        m_imem[18] = enc_i(15, 0, 12, 16'h8000);
        m_imem[19] = enc_r(8, 31, 0, 0);
        m_imem[20] = enc_r(34, 12, 11, 13);
        m_imem[21] = enc_r(42, 12, 11, 14);
        m_imem[22] = 32'hFFFF_FFFF;
        m_imem[23] = enc_j(2, 23);
        m_dmem[1]  = 32'hCAFE_F00D;
        for (int r = 0; r < 32; r++) m_reg[r] = 32'd0;
        m_pc = 32'd0;

        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = m_imem[i];
            dmem_we = 1'b1; dmem_waddr = 6'(i); dmem_wdata = m_dmem[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        dmem_we = 1'b0;

        // R1: reset state
        #1;
        chk("R1", "pc after reset", dbg_pc, 32'd0);
        for (int r = 0; r < 32; r++) begin
            logic [31:0] v;
            reg_at(r, v);
            chk("R1", $sformatf("reg %0d after reset", r), v, 32'd0);
        end

        @(negedge clk);
        rst = 1'b0;

        // R2: lockstep against the instruction-level model
        for (int k = 0; k < RUN; k++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            dbg_reg_sel = 5'(k % 32);
            #1;
            chk("R2", "pc lockstep", dbg_pc, m_pc);
            chk("R2", $sformatf("reg %0d lockstep", k % 32), dbg_reg_data, m_reg[k % 32]);
        end

        begin
            logic [31:0] v;
            reg_at(0, v);  chk("R3", "reg0 after add into it", v, 32'd0);
            reg_at(6, v);  chk("R4", "sub 0 - (-5)", v, 32'd5);
            reg_at(2, v);  chk("R4", "addi sign-extended", v, 32'hFFFF_FFFB);
            reg_at(13, v); chk("R4", "sub wraps", v, 32'h7FFF_FFF9);
            reg_at(4, v);  chk("R5", "slt -5 < 0", v, 32'd1);
            reg_at(5, v);  chk("R5", "slti positive < -1", v, 32'd0);
            reg_at(14, v); chk("R5", "slt signed min < 7", v, 32'd1);
            reg_at(3, v);  chk("R6", "andi zero-extended", v, 32'h0000_FF0B);
            reg_at(1, v);  chk("R7", "lui then ori", v, 32'h1234_ABCD);
            reg_at(12, v); chk("R7", "lui clears low half", v, 32'h8000_0000);
            reg_at(8, v);  chk("R8", "lw after sw", v, 32'h1234_ABCD);
            reg_at(9, v);  chk("R8", "lw negative offset preload", v, 32'hCAFE_F00D);
            reg_at(10, v); chk("R9", "bne skipped instruction", v, 32'd0);
            reg_at(31, v); chk("R10", "jal link value", v, 32'd64);
            reg_at(11, v); chk("R11", "jr return executed", v, 32'd7);
            reg_at(31, v); chk("R12", "undefined op left r31", v, 32'd64);
            chk("R10", "j self-loop pc", dbg_pc, 32'd92);
            for (int r = 0; r < 32; r++) begin
                reg_at(r, v);
                chk("R2", $sformatf("final reg %0d", r), v, m_reg[r]);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule